// File: doc/BRIEF.md
# Boundary Scan Register with Test Modes

This block is a chain of twenty boundary cells placed between a chip's core logic and its pins. A test access port outside the block supplies the test clock, an active-low test reset, the data-register capture, shift and update strobes, serial input data and an already decoded instruction code. The block returns the serial output and the multiplexed signals on both sides of the cell chain: pin data, pin output enables and core inputs.

Each cell has two stages. The shift stage loads on the rising test clock, either in parallel from the capture source or serially toward the output. The update stage loads on the falling test clock while the update strobe is high. Pins and core inputs only ever see update-stage values, so a serial load never shows a partial pattern. There are eight input cells and four two-state output cells. Four tri-state outputs each use two cells: a data cell and its own enable cell. The enable cell lets the chain drive a pin low, drive it high, or release it.

The instruction code selects one of four modes, and the mode follows the code at once. Under BYPASS, pins and core pass through and a one-bit register forms the serial path. Under SAMPLE, pins and core still pass through and the boundary chain is selected. Under EXTEST, pins are driven from the update stage. Under INTEST, the core inputs and the pins are driven from the update stage. The mode changes whenever the instruction code changes. No other state or transition exists.

Top module: `boundary_scan_reg`

## Requirements
- R1: Instruction code 3'd1 selects SAMPLE, 3'd2 selects EXTEST and 3'd3 selects INTEST. Every other code selects BYPASS. Under BYPASS and SAMPLE, `pin_out` equals `core_out_data`, `pin_oe` equals `core_out_en` and `core_in` equals `pin_in`.
- R2: The chain has 20 cells, with cell 0 nearest `tdo` and cell 19 nearest `tdi`. Cells 0 to 7 serve `pin_in[0..7]`. Cells 8 to 11 serve `pin_out[0..3]`. For tri-state pin t (0 to 3), cell 12+2t holds the data for `pin_out[4+t]` and cell 13+2t holds the enable `pin_oe[t]`.
- R3: When the chain is selected and `shift_dr` is high, each rising `tck` moves every cell one place toward `tdo`, and `tdi` enters cell 19. `tdo` takes cell 0 on every falling `tck`.
- R4: Under SAMPLE, a capture loads `pin_in` into the input cells, and loads `core_out_data` and `core_out_en` into the output data cells and enable cells.
- R5: Under EXTEST, `pin_out` and `pin_oe` come from the update stage. A capture loads `pin_in` into the input cells and loads the values currently driven from the update stage into the output cells.
- R6: Under INTEST, `core_in` comes from the input cells' update stage and the pins come from the update stage. A capture loads the core output values into the output cells.
- R7: The update stage loads the entire shift stage on a falling `tck` while `update_dr` is high and the chain is selected. Pins do not change while a pattern is shifted.
- R8: Under BYPASS, the serial path is one register. Capture loads 0 into it, and each shift delays `tdi` by one `tck` on its way to `tdo`.
- R9: While `trst_n` is low, the shift stage, the update stage, the bypass bit and `tdo` are all 0. Every tri-state enable driven from the chain is therefore off.
- R10: Under BYPASS, the capture, shift and update strobes leave the boundary update stage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| capture_dr | input | 1 | Data-register capture strobe |
| shift_dr | input | 1 | Data-register shift strobe |
| update_dr | input | 1 | Data-register update strobe |
| tdi | input | 1 | Serial test data in |
| instr | input | 3 | Decoded current instruction code |
| tdo | output | 1 | Serial test data out, changes on falling tck |
| core_out_data | input | 8 | Core values for the eight output pins |
| core_out_en | input | 4 | Core enables for the four tri-state pins |
| pin_in | input | 8 | Levels seen at the input pins |
| pin_out | output | 8 | Data driven to the output pins |
| pin_oe | output | 4 | Output enables of the tri-state pins |
| core_in | output | 8 | Input values handed to the core |

## Verification
On the falling edge that ends a scan, the tdo register and the update stage both load from the shift stage. The final serial bit and the new pin pattern therefore appear together. The bench shifts a full pattern and then raises update directly after the last shift. The scoreboard expects the first bit shifted in on `tdo` at that edge, and a direct check expects the pins to show the whole new pattern at the same moment. Just before the update, a second check confirms that the pins still show the previous pattern.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    parameter int INSTR_W = 3;

    localparam logic [INSTR_W-1:0] OP_SAMPLE = 3'd1;
    localparam logic [INSTR_W-1:0] OP_EXTEST = 3'd2;
    localparam logic [INSTR_W-1:0] OP_INTEST = 3'd3;

    typedef enum logic [1:0] {
        M_BYPASS = 2'd0,
        M_SAMPLE = 2'd1,
        M_EXTEST = 2'd2,
        M_INTEST = 2'd3
    } bsr_mode_e;

    // Every code outside the three chain instructions selects the bypass path.
    function automatic bsr_mode_e decode_instr(input logic [INSTR_W-1:0] code);
        bsr_mode_e m;
        unique case (code)
            OP_SAMPLE: m = M_SAMPLE;
            OP_EXTEST: m = M_EXTEST;
            OP_INTEST: m = M_INTEST;
            default:   m = M_BYPASS;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bsr_chain.sv
module bsr_chain #(
    parameter int N = 20
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         sel,
    input  logic         capture_dr,
    input  logic         shift_dr,
    input  logic         update_dr,
    input  logic         tdi,
    input  logic [N-1:0] cap_i,
    output logic         ser_o,
    output logic [N-1:0] upd_o
);

    logic [N-1:0] sh_q;
    logic [N-1:0] upd_q;

    // Shift stage: parallel capture or serial move toward cell 0.
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sh_q <= '0;
        end else if (sel && capture_dr) begin
            sh_q <= cap_i;
        end else if (sel && shift_dr) begin
            sh_q <= {tdi, sh_q[N-1:1]};
        end
    end

    // Update stage: the whole pattern moves in one falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            upd_q <= '0;
        end else if (sel && update_dr) begin
            upd_q <= sh_q;
        end
    end

    assign ser_o = sh_q[0];
    assign upd_o = upd_q;

    AST_CAPTURE_LOADS: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && capture_dr) |=> (sh_q == $past(cap_i))); // R4

    AST_SHIFT_ENTRY: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && shift_dr && !capture_dr) |=>
            (sh_q[N-1] == $past(tdi)) && (sh_q[N-2:0] == $past(sh_q[N-1:1]))); // R3

    AST_HOLD_WITHOUT_UPDATE: assert property (@(negedge tck) disable iff (!trst_n)
        !(sel && update_dr) |=> $stable(upd_q)); // R7

endmodule

// File: rtl/bsr_bypass.sv
module bsr_bypass (
    input  logic tck,
    input  logic trst_n,
    input  logic sel,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic tdi,
    output logic ser_o
);

    logic byp_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            byp_q <= 1'b0;
        end else if (sel && capture_dr) begin
            byp_q <= 1'b0;
        end else if (sel && shift_dr) begin
            byp_q <= tdi;
        end
    end

    assign ser_o = byp_q;

    AST_BYP_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && capture_dr) |=> (byp_q == 1'b0)); // R8

    AST_BYP_ONE_STAGE: assert property (@(posedge tck) disable iff (!trst_n)
        (sel && shift_dr && !capture_dr) |=> (byp_q == $past(tdi))); // R8

endmodule

// File: rtl/bsr_cell_map.sv
module bsr_cell_map
    import bsr_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_OUT2 = 4,
    parameter int N_TRI  = 4,
    localparam int N_OUT  = N_OUT2 + N_TRI,
    localparam int N_CELL = N_IN + N_OUT2 + 2 * N_TRI
) (
    input  bsr_mode_e         mode,
    input  logic [N_CELL-1:0] upd_i,
    input  logic [N_OUT-1:0]  core_out_data,
    input  logic [N_TRI-1:0]  core_out_en,
    input  logic [N_IN-1:0]   pin_in,
    output logic [N_CELL-1:0] cap_o,
    output logic [N_OUT-1:0]  pin_out,
    output logic [N_TRI-1:0]  pin_oe,
    output logic [N_IN-1:0]   core_in
);

    logic pins_from_chain;
    logic core_from_chain;
    logic cap_driven;

    always_comb begin
        pins_from_chain = 1'b0;
        core_from_chain = 1'b0;
        cap_driven      = 1'b0;
        unique case (mode)
            M_BYPASS: ;
            M_SAMPLE: ;
            M_EXTEST: begin
                pins_from_chain = 1'b1;
                cap_driven      = 1'b1;
            end
            M_INTEST: begin
                pins_from_chain = 1'b1;
                core_from_chain = 1'b1;
            end
        endcase
    end

    // Input cells: capture the pad level, optionally feed the core.
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign cap_o[i]   = pin_in[i];
        assign core_in[i] = core_from_chain ? upd_i[i] : pin_in[i];
    end

    // Two-state output cells.
    for (genvar j = 0; j < N_OUT2; j++) begin : g_out2
        localparam int C = N_IN + j;
        assign cap_o[C]   = cap_driven ? upd_i[C] : core_out_data[j];
        assign pin_out[j] = pins_from_chain ? upd_i[C] : core_out_data[j];
    end

    // Tri-state outputs: data cell followed by its enable cell.
    for (genvar t = 0; t < N_TRI; t++) begin : g_tri
        localparam int CD = N_IN + N_OUT2 + 2 * t;
        localparam int CE = CD + 1;
        assign cap_o[CD]          = cap_driven ? upd_i[CD] : core_out_data[N_OUT2+t];
        assign cap_o[CE]          = cap_driven ? upd_i[CE] : core_out_en[t];
        assign pin_out[N_OUT2+t]  = pins_from_chain ? upd_i[CD] : core_out_data[N_OUT2+t];
        assign pin_oe[t]          = pins_from_chain ? upd_i[CE] : core_out_en[t];
    end

endmodule

// File: rtl/boundary_scan_reg.sv
module boundary_scan_reg
    import bsr_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int N_OUT2 = 4,
    parameter int N_TRI  = 4,
    localparam int N_OUT  = N_OUT2 + N_TRI,
    localparam int N_CELL = N_IN + N_OUT2 + 2 * N_TRI
) (
    input  logic               tck,
    input  logic               trst_n,
    input  logic               capture_dr,
    input  logic               shift_dr,
    input  logic               update_dr,
    input  logic               tdi,
    input  logic [INSTR_W-1:0] instr,
    output logic               tdo,
    input  logic [N_OUT-1:0]   core_out_data,
    input  logic [N_TRI-1:0]   core_out_en,
    input  logic [N_IN-1:0]    pin_in,
    output logic [N_OUT-1:0]   pin_out,
    output logic [N_TRI-1:0]   pin_oe,
    output logic [N_IN-1:0]    core_in
);

    bsr_mode_e         mode;
    logic              chain_sel;
    logic              chain_ser;
    logic              byp_ser;
    logic [N_CELL-1:0] cap_vec;
    logic [N_CELL-1:0] upd_vec;
    logic              tdo_q;

    always_comb begin
        mode      = decode_instr(instr);
        chain_sel = (mode != M_BYPASS);
    end

    bsr_chain #(.N(N_CELL)) u_chain (
        .tck        (tck),
        .trst_n     (trst_n),
        .sel        (chain_sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .tdi        (tdi),
        .cap_i      (cap_vec),
        .ser_o      (chain_ser),
        .upd_o      (upd_vec)
    );

    bsr_bypass u_bypass (
        .tck        (tck),
        .trst_n     (trst_n),
        .sel        (!chain_sel),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .tdi        (tdi),
        .ser_o      (byp_ser)
    );

    bsr_cell_map #(.N_IN(N_IN), .N_OUT2(N_OUT2), .N_TRI(N_TRI)) u_map (
        .mode          (mode),
        .upd_i         (upd_vec),
        .core_out_data (core_out_data),
        .core_out_en   (core_out_en),
        .pin_in        (pin_in),
        .cap_o         (cap_vec),
        .pin_out       (pin_out),
        .pin_oe        (pin_oe),
        .core_in       (core_in)
    );

    // Serial output retimed to the falling edge.
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo_q <= 1'b0;
        end else begin
            tdo_q <= chain_sel ? chain_ser : byp_ser;
        end
    end

    assign tdo = tdo_q;

    AST_PINS_QUIET_IN_BYPASS: assert property (@(posedge tck) disable iff (!trst_n)
        (mode == M_BYPASS) |-> (pin_out == core_out_data && pin_oe == core_out_en)); // R1

endmodule

// File: tb/test_boundary_scan_reg.sv
module test_boundary_scan_reg;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       capture_dr = 1'b0;
    logic       shift_dr = 1'b0;
    logic       update_dr = 1'b0;
    logic       tdi = 1'b0;
    logic [2:0] instr = 3'd2;
    logic       tdo;
    logic [7:0] core_out_data = 8'hA5;
    logic [3:0] core_out_en = 4'h9;
    logic [7:0] pin_in = 8'h3C;
    logic [7:0] pin_out;
    logic [3:0] pin_oe;
    logic [7:0] core_in;

    int n_cmp = 0;
    int n_bad = 0;
    bit summary_done = 0;

    logic  sb_bits[$];
    string sb_tags[$];
    logic  adv_seen = 1'b0;

    always #5 tck = ~tck;

    boundary_scan_reg i_boundary_scan_reg (
        .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .instr(instr), .tdo(tdo),
        .core_out_data(core_out_data), .core_out_en(core_out_en), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .core_in(core_in)
    );

    // Layout from R2.
    function automatic logic [19:0] build_cap(input logic [7:0] pi, input logic [7:0] d,
                                              input logic [3:0] e);
        logic [19:0] c;
        c[7:0]  = pi;
        c[11:8] = d[3:0];
        for (int t = 0; t < 4; t++) begin
            c[12+2*t] = d[4+t];
            c[13+2*t] = e[t];
        end
        return c;
    endfunction

    function automatic logic [7:0] pat_data(input logic [19:0] p);
        return {p[18], p[16], p[14], p[12], p[11:8]};
    endfunction

    function automatic logic [3:0] pat_en(input logic [19:0] p);
        return {p[19], p[17], p[15], p[13]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: one serial bit is expected after each falling edge that follows an advancing edge.
    always @(posedge tck) adv_seen <= capture_dr | shift_dr;

    always @(negedge tck) begin
        #2;
        if (adv_seen && sb_bits.size() > 0) begin
            logic  eb;
            string et;
            eb = sb_bits.pop_front();
            et = sb_tags.pop_front();
            n_cmp++;
            if (tdo !== eb) begin
                n_bad++;
                $display("FAIL %s tdo actual=%0b expected=%0b", et, tdo, eb);
            end
        end
    end

    // Driver: capture, then shift a full chain while pushing the expected serial stream.
    task automatic scan_shift(input logic [19:0] din, input logic [19:0] cap_exp, input string tag);
        @(posedge tck); #1;
        capture_dr = 1'b1;
        for (int k = 0; k < 20; k++) begin
            sb_bits.push_back(cap_exp[k]);
            sb_tags.push_back(tag);
        end
        sb_bits.push_back(din[0]);
        sb_tags.push_back("R3");
        for (int k = 0; k < 20; k++) begin
            @(posedge tck); #1;
            capture_dr = 1'b0;
            shift_dr   = 1'b1;
            tdi        = din[k];
        end
        @(posedge tck); #1;
        shift_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        @(posedge tck); #1;
        update_dr = 1'b0;
    endtask

    localparam logic [19:0] P1 = 20'hC96A1;
    localparam logic [19:0] P2 = 20'h35E7B;
    localparam logic [19:0] P3 = 20'hAC4D2;

    initial begin
        // R9: reset state seen under EXTEST
        repeat (3) @(posedge tck);
        #1;
        check("R9 pin_oe", pin_oe, 4'h0);
        check("R9 pin_out", pin_out, 8'h00);
        check("R9 tdo", tdo, 1'b0);
        trst_n = 1'b1;

        // R1: functional pass-through under a bypass code
        instr = 3'd0;
        @(posedge tck); #1;
        check("R1 pin_out", pin_out, 8'hA5);
        check("R1 pin_oe", pin_oe, 4'h9);
        check("R1 core_in", core_in, 8'h3C);
        instr = 3'd6;
        core_out_data = 8'h5A; pin_in = 8'hC3;
        #1;
        check("R1 pin_out code6", pin_out, 8'h5A);
        check("R1 core_in code6", core_in, 8'hC3);
        core_out_data = 8'hA5; pin_in = 8'h3C;

        // R4: SAMPLE capture and preload; pins stay functional (R1)
        instr = 3'd1;
        scan_shift(P1, build_cap(8'h3C, 8'hA5, 4'h9), "R4");
        do_update();
        check("R1 sample pin_out", pin_out, 8'hA5);
        check("R1 sample pin_oe", pin_oe, 4'h9);

        // R5: EXTEST drives the preloaded pattern
        instr = 3'd2;
        #1;
        check("R5 pin_out", pin_out, pat_data(P1));
        check("R5 pin_oe", pin_oe, pat_en(P1));
        check("R5 core_in", core_in, 8'h3C);
        scan_shift(P2, build_cap(8'h3C, pat_data(P1), pat_en(P1)), "R5");
        check("R7 hold pin_out", pin_out, pat_data(P1));
        check("R7 hold pin_oe", pin_oe, pat_en(P1));
        do_update();
        check("R7 new pin_out", pin_out, pat_data(P2));
        check("R7 new pin_oe", pin_oe, pat_en(P2));

        // R8: bypass path, capture 0 then one-cycle delay
        instr = 3'd4;
        @(posedge tck); #1;
        capture_dr = 1'b1;
        sb_bits.push_back(1'b0); sb_tags.push_back("R8");
        for (int k = 0; k < 4; k++) begin
            sb_bits.push_back(k != 1); sb_tags.push_back("R8");
        end
        for (int k = 0; k < 4; k++) begin
            @(posedge tck); #1;
            capture_dr = 1'b0;
            shift_dr   = 1'b1;
            tdi        = (k != 1);
        end
        @(posedge tck); #1;
        shift_dr = 1'b0;
        do_update();
        check("R8 stream drained", sb_bits.size(), 0);

        // R10: boundary update stage untouched by bypass activity
        instr = 3'd2;
        #1;
        check("R10 pin_out", pin_out, pat_data(P2));
        check("R10 pin_oe", pin_oe, pat_en(P2));

        // R6: INTEST
        instr = 3'd3;
        scan_shift(P3, build_cap(8'h3C, 8'hA5, 4'h9), "R6");
        do_update();
        check("R6 core_in", core_in, P3[7:0]);
        check("R6 pin_out", pin_out, pat_data(P3));
        check("R6 pin_oe", pin_oe, pat_en(P3));

        // R9: reset mid-test disables all enables
        trst_n = 1'b0;
        #2;
        check("R9 late pin_oe", pin_oe, 4'h0);
        check("R9 late core_in", core_in, 8'h00);
        check("R9 late tdo", tdo, 1'b0);
        @(posedge tck); #1;
        trst_n = 1'b1;

        check("R2 scoreboard drained", sb_bits.size(), 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge tck);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule